// File: doc/BRIEF.md
# Pipelined Heap Priority Queue

This block keeps a set of distinct 32-bit priority values and always hands back the largest on request. The values live in a complete binary tree of `LEVELS` levels. Each tree level has its own slice of storage and its own compare-and-steer stage. An operation enters at the root as a token and moves down one level per clock. Because of this, a new operation can start while earlier ones are still moving through the lower levels.

An enqueue keeps the larger of the carried value and the node value at each level and carries the smaller one onward. Every node keeps a count of the empty slots in its subtree. The token uses these counts to pick a child that still has room, taking the left child first. A dequeue takes the root value out. The hole it leaves then sinks down the tree: at each level the larger valid child is moved up, and the counts along that path are raised. An empty slot is marked by a valid bit, so value 0 is an ordinary priority.

The caller watches `ready` and raises exactly one of the two requests. Requests made while `ready` is low are ignored. A request that cannot be served gives a one-cycle error pulse.

Top module: `pheap_pq`

## Requirements
- R1: During and right after synchronous active-low reset: `empty`=1, `full`=0, `ready`=1, `deq_valid`=0, `err`=0.
- R2: An accepted dequeue gives `deq_valid`=1 in the next cycle, with `deq_data` equal to the largest value stored at acceptance. The entry is then removed. `deq_valid` is 0 in every other cycle.
- R3: Suppose an accepted operation has to continue below the root. This is an enqueue into a non-empty queue, or a dequeue when two or more entries are stored. Then `ready` is 0 for exactly the next cycle. Any other cycle has `ready`=1.
- R4: A request made while `ready`=0 is ignored. It causes no error pulse and does not change the stored contents.
- R5: An enqueue while `full`=1 (and `ready`=1) gives `err`=1 in the next cycle. It leaves the contents unchanged.
- R6: A dequeue while `empty`=1 (and `ready`=1) gives `err`=1 in the next cycle, with no `deq_valid`.
- R7: Raising enqueue and dequeue together while `ready`=1 gives `err`=1 in the next cycle. Neither operation is performed.
- R8: `full` is 1 exactly when 2^LEVELS−1 entries are stored, and `empty` is 1 exactly when none are. Both flags change in the cycle after the accepted operation.
- R9: The queue holds up to 2^LEVELS−1 distinct values, including 0 and 0xFFFFFFFF. Draining it returns them in strictly descending order.
- R10: Mixed enqueues and dequeues issued as fast as `ready` allows give the same results as an ideal sorted set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_req | input | 1 | Enqueue request |
| enq_data | input | 32 | Priority value to insert |
| deq_req | input | 1 | Dequeue request |
| ready | output | 1 | A request is accepted in this cycle |
| deq_valid | output | 1 | Dequeued value is on `deq_data` |
| deq_data | output | 32 | Largest value removed by the last dequeue |
| err | output | 1 | One-cycle pulse for a rejected request |
| empty | output | 1 | No entries stored |
| full | output | 1 | All slots used |

## Verification
On every cycle the assertions check four things. They check that each valid node has a valid parent holding a value no smaller than its own. They check that an enqueue token reaching the bottom level always finds an empty slot. They check that `ready` is never low for two cycles in a row, and that the rejection rules produce the error pulse. Only the bench scenarios can show that the values come out in the right order over many overlapping operations, that the free-slot steering really fills the tree to full capacity, and that ignored requests leave no trace. For this the bench compares every output with a sorted-set model on every cycle.

// File: rtl/pheap_pq.sv
module pheap_pq #(
  parameter int LEVELS = 4,
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enq_req,
  input  logic [W-1:0] enq_data,
  input  logic         deq_req,
  output logic         ready,
  output logic         deq_valid,
  output logic [W-1:0] deq_data,
  output logic         err,
  output logic         empty,
  output logic         full
);
  localparam int N  = (1 << LEVELS) - 1;
  localparam int IW = LEVELS;
  localparam int CW = $clog2(N + 1);

  logic [W-1:0]  mem [0:N];
  logic [N:0]    vld;
  logic [CW-1:0] cap [0:N];
  logic [CW-1:0] count;

  logic [LEVELS:2] t_v, t_dq;
  logic [W-1:0]    t_val [2:LEVELS];
  logic [IW-1:0]   t_pos [2:LEVELS];

  logic [LEVELS:1] c_v, c_dq;
  logic [W-1:0]    c_val [1:LEVELS];
  logic [IW-1:0]   c_pos [1:LEVELS];

  logic [LEVELS:1] s_go, s_wvld;
  logic [W-1:0]    s_wdat [1:LEVELS];
  logic [W-1:0]    s_carry [1:LEVELS];
  logic [IW-1:0]   s_ch [1:LEVELS];

  logic acc;

  assign empty = (count == '0);
  assign full  = (count == CW'(N));
  assign ready = !t_v[2];
  assign acc   = ready && (enq_req ^ deq_req) && !(enq_req && full) && !(deq_req && empty);

  function automatic int sub_size(int i);
    int d;
    d = 0;
    for (int b = 0; b < LEVELS; b++)
      if (i >= (1 << b)) d = b;
    return (1 << (LEVELS - d)) - 1;
  endfunction

  always_comb begin
    c_v = '0;
    c_dq = '0;
    c_v[1]   = acc;
    c_dq[1]  = deq_req;
    c_val[1] = enq_data;
    c_pos[1] = IW'(1);
    for (int k = 2; k <= LEVELS; k++) begin
      c_v[k]   = t_v[k];
      c_dq[k]  = t_dq[k];
      c_val[k] = t_val[k];
      c_pos[k] = t_pos[k];
    end
  end

  always_comb begin
    for (int k = 1; k <= LEVELS; k++) begin
      logic [IW-1:0] p, lc, rc, pick;
      logic bigger, lv, rv;
      p      = c_pos[k];
      lc     = {p[IW-2:0], 1'b0};
      rc     = {p[IW-2:0], 1'b1};
      bigger = c_val[k] > mem[p];
      lv     = (k < LEVELS) && vld[lc];
      rv     = (k < LEVELS) && vld[rc];
      pick   = (lv && (!rv || mem[lc] > mem[rc])) ? lc : rc;
      if (!c_dq[k]) begin
        s_wvld[k]  = 1'b1;
        s_wdat[k]  = (!vld[p] || bigger) ? c_val[k] : mem[p];
        s_carry[k] = bigger ? mem[p] : c_val[k];
        s_go[k]    = vld[p] && (k < LEVELS);
        s_ch[k]    = (cap[lc] != '0) ? lc : rc;
      end else begin
        s_wvld[k]  = lv || rv;
        s_wdat[k]  = mem[pick];
        s_carry[k] = c_val[k];
        s_go[k]    = lv || rv;
        s_ch[k]    = pick;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      t_v       <= '0;
      t_dq      <= '0;
      count     <= '0;
      deq_valid <= 1'b0;
      deq_data  <= '0;
      err       <= 1'b0;
      for (int i = 0; i <= N; i++) cap[i] <= CW'(sub_size(i));
    end else begin
      deq_valid <= acc && deq_req;
      err       <= ready && (enq_req || deq_req) && !acc;
      if (acc && deq_req) deq_data <= mem[1];
      if (acc) count <= deq_req ? count - 1'b1 : count + 1'b1;
      for (int k = 1; k <= LEVELS; k++) begin
        if (c_v[k]) begin
          mem[c_pos[k]] <= s_wdat[k];
          vld[c_pos[k]] <= s_wvld[k];
          if (s_go[k])
            cap[s_ch[k]] <= c_dq[k] ? cap[s_ch[k]] + 1'b1 : cap[s_ch[k]] - 1'b1;
        end
      end
      for (int k = 2; k <= LEVELS; k++) begin
        t_v[k]   <= c_v[k-1] && s_go[k-1];
        t_dq[k]  <= c_dq[k-1];
        t_val[k] <= s_carry[k-1];
        t_pos[k] <= s_ch[k-1];
      end
    end
  end

  for (genvar i = 2; i <= N; i++) begin : g_order
    // R9
    heap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld[i] |-> (vld[i/2] && mem[i/2] >= mem[i]));
  end

  // R9
  leaf_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_v[LEVELS] && !c_dq[LEVELS]) |-> !vld[c_pos[LEVELS]]);

  // R3
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);

  // R5
  full_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && enq_req && !deq_req && full) |=> (err && !deq_valid));

  // R6
  empty_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && deq_req && !enq_req && empty) |=> (err && !deq_valid));

  // R7
  both_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && enq_req && deq_req) |=> (err && !deq_valid));

  // R2
  out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid |-> !err);
endmodule

// File: tb/pheap_pq_test.sv
module pheap_pq_test;
  localparam int LEVELS = 4;
  localparam int N = (1 << LEVELS) - 1;

  logic clk = 0, rst_n = 0;
  logic enq_req = 0, deq_req = 0;
  logic [31:0] enq_data = 0;
  logic ready, deq_valid, err, empty, full;
  logic [31:0] deq_data;

  int nchk = 0, nfail = 0;
  logic [31:0] m_q[$];
  logic m_ready = 1, m_dv = 0, m_err = 0;
  logic [31:0] m_data = 0;
  int ignored = 0, accepted = 0;

  pheap_pq #(.LEVELS(LEVELS), .W(32)) uut (
    .clk(clk), .rst_n(rst_n), .enq_req(enq_req), .enq_data(enq_data),
    .deq_req(deq_req), .ready(ready), .deq_valid(deq_valid), .deq_data(deq_data),
    .err(err), .empty(empty), .full(full));

  always #5 clk = ~clk;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit inq(logic [31:0] v);
    foreach (m_q[i]) if (m_q[i] == v) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] fresh();
    logic [31:0] v;
    v = $urandom;
    while (inq(v)) v++;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete();
      m_ready = 1; m_dv = 0; m_err = 0; m_data = 0;
    end else begin
      int sz;
      bit a;
      sz = m_q.size();
      a = m_ready && (enq_req ^ deq_req) && !(enq_req && sz == N) && !(deq_req && sz == 0);
      if (!m_ready && (enq_req || deq_req)) ignored++;
      m_dv  = a && deq_req;
      m_err = m_ready && (enq_req || deq_req) && !a;
      if (a) accepted++;
      if (a && deq_req) m_data = m_q.pop_front();
      if (a && enq_req) begin
        int pos;
        pos = m_q.size();
        for (int i = 0; i < m_q.size(); i++)
          if (m_q[i] < enq_data) begin pos = i; break; end
        m_q.insert(pos, enq_data);
      end
      m_ready = !(a && ((enq_req && sz >= 1) || (deq_req && sz >= 2)));
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ready == m_ready, "R3 ready", 32'(ready), 32'(m_ready));
      chk(empty == (m_q.size() == 0), "R8 empty", 32'(empty), 32'(m_q.size() == 0));
      chk(full == (m_q.size() == N), "R8 full", 32'(full), 32'(m_q.size() == N));
      chk(deq_valid == m_dv, "R2 deq_valid", 32'(deq_valid), 32'(m_dv));
      if (m_dv) chk(deq_data == m_data, "R10 deq_data", deq_data, m_data);
      chk(err == m_err, "R5 R6 R7 err", 32'(err), 32'(m_err));
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #(10 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic op(bit e, bit d, logic [31:0] v);
    while (!ready) @(negedge clk);
    enq_req = e; deq_req = d; enq_data = v;
    @(negedge clk);
    enq_req = 0; deq_req = 0;
  endtask

  initial begin
    logic [31:0] prev;
    bit have;
    repeat (3) @(negedge clk);
    chk(empty && !full && ready && !deq_valid && !err, "R1 reset outputs",
        {27'd0, empty, full, ready, deq_valid, err}, 32'b10100);
    rst_n = 1;
    @(negedge clk);
    chk(empty && ready && !err, "R1 after release", {29'd0, empty, ready, err}, 32'b110);

    // fill, holding enqueue; requests while not ready are ignored (R4)
    enq_req = 1; enq_data = 32'h0;
    while (m_q.size() < N) begin
      @(negedge clk);
      if (m_q.size() == 1) enq_data = 32'hFFFF_FFFF;
      else enq_data = fresh();
    end
    enq_req = 0;
    @(negedge clk);
    chk(full == 1, "R8 full after fill", 32'(full), 1);
    chk(ignored > 0, "R4 ignored requests seen", ignored, 1);

    // enqueue while full
    op(1, 0, 32'h1234_5678);
    chk(err == 1, "R5 err on full", 32'(err), 1);
    chk(full == 1, "R5 still full", 32'(full), 1);

    // drain, holding dequeue
    have = 0;
    deq_req = 1;
    while (m_q.size() > 0 || deq_valid) begin
      @(negedge clk);
      if (m_q.size() == 0) deq_req = 0;
      if (deq_valid) begin
        if (have) chk(deq_data < prev, "R9 descending drain", deq_data, prev);
        prev = deq_data; have = 1;
      end
    end
    deq_req = 0;
    chk(prev == 32'h0, "R9 smallest value 0 last", prev, 0);
    @(negedge clk);

    op(0, 1, 0);
    chk(err == 1 && !deq_valid, "R6 err on empty", {30'd0, err, deq_valid}, 32'b10);

    op(1, 1, 32'd77);
    chk(err == 1, "R7 err on both", 32'(err), 1);
    @(negedge clk);
    chk(empty == 1, "R7 nothing stored", 32'(empty), 1);

    op(1, 0, 32'd5);
    op(1, 0, 32'd9);
    op(1, 0, 32'd3);
    while (!ready) @(negedge clk);
    deq_req = 1;
    @(negedge clk);
    deq_req = 0;
    chk(deq_valid && deq_data == 32'd9, "R2 largest returned", deq_data, 32'd9);

    // mixed traffic at full rate
    accepted = 0;
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom % 16;
      enq_req = (r < 7) || (r == 15);
      deq_req = (r >= 7 && r < 13) || (r == 15);
      enq_data = (r % 5 == 0) ? fresh() & 32'h3F : fresh();
      while (inq(enq_data)) enq_data++;
      @(negedge clk);
    end
    enq_req = 0; deq_req = 0;
    chk(accepted > 1000, "R10 sustained overlap", accepted, 1000);
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end
endmodule